// File: doc/BRIEF.md
# Permission-Checking Translation Cache

This block is a small fully associative cache of address translations that sits between a memory requester and a page-table walker. Each access presents a virtual page number (VPN), an access kind and a privilege flag. When a valid entry holds that VPN, the block answers one cycle later with the physical page number (PPN), or with a permission fault if the cached rights do not allow the access. No walker request is made in that case.

When no entry matches, the block asks the walker for the translation and waits for it. It then installs the result and answers the requester. If the walker reports a fault, that fault goes back to the requester and nothing is stored. A faulting page therefore never takes up a slot.

Software keeps the cache coherent with two commands. The first drops the one entry that holds a given VPN, and is used after a page-table entry has been rewritten. The second clears every entry in a single cycle, and is used when the table root changes. With the single-page command, a write to a shared read-only page traps even on a hit, and the same write succeeds once software has put in a writable mapping and dropped the stale entry.

Top module: `xlat_cache`

## Requirements
- R1: A request accepted while `req_ready` is high whose VPN matches a valid entry gives `rsp_valid` on the next cycle. `rsp_ppn` is the cached PPN and `walk_req` stays low.
- R2: An accepted request that matches no entry raises `walk_req` on the next cycle, with `walk_vpn` equal to the request VPN. `walk_req` stays high until `walk_done`, and `rsp_valid` follows one cycle after `walk_done`. A non-faulting walk result is installed, so a later access to that page hits without a walk.
- R3: Permission bits are `perm[0]`=readable, `perm[1]`=writable, `perm[2]`=executable and `perm[3]`=user-accessible. `req_kind` 00 (load) needs readable, 01 (store) needs writable and 10 (fetch) needs executable; 11 always faults. The check applies on hits and on walk results alike.
- R4: When `req_user` is 1, the access also needs `perm[3]`. Supervisor accesses (`req_user`=0) ignore `perm[3]`.
- R5: A faulting response has `rsp_fault`=1, `rsp_ppn`=0 and a non-zero `rsp_cause`. `rsp_cause` is 00 for no fault, 01 for a permission violation and 10 for a walker fault. A permission fault that comes from a walk result still installs the entry.
- R6: A `walk_fault` result is answered with cause 10 and is not installed, so the next access to that page walks again.
- R7: `inv_valid` with `inv_vpn` removes the entry holding that VPN. Other entries keep hitting.
- R8: `flush_all` makes every entry invalid on the next cycle.
- R9: A fill uses the lowest-numbered invalid slot when one exists. When all slots are valid, victims are taken in round-robin order starting at slot 0 after reset.
- R10: An invalidation of a VPN in the same cycle as a lookup of that VPN makes the lookup miss. A walk result returning in the same cycle as `flush_all`, or as an invalidation of its own VPN, is answered but not installed.
- R11: `req_ready` is low while a walk is pending. Requests presented then are ignored and produce no response.
- R12: After reset every entry is invalid, `req_ready` is 1 and `rsp_valid` and `walk_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_vpn | input | 36 | Virtual page number of the access |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch |
| req_user | input | 1 | 1 = user-mode access |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response strobe |
| rsp_ppn | output | 40 | Translated physical page number (0 on fault) |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 2 | 00 none, 01 permission, 10 walker |
| walk_req | output | 1 | Translation request to the walker |
| walk_vpn | output | 36 | VPN to walk |
| walk_done | input | 1 | Walker result strobe |
| walk_ppn | input | 40 | PPN from the walker |
| walk_perm | input | 4 | Permission bits from the walker |
| walk_fault | input | 1 | Walker could not translate |
| inv_valid | input | 1 | Invalidate-one-page strobe |
| inv_vpn | input | 36 | VPN to invalidate |
| flush_all | input | 1 | Clear every entry |

## Verification
Two pairs of functions can fall in the same cycle. A lookup can meet an invalidation of the same page, and a walker return can meet a full flush or an invalidation of the page being walked. The bench provokes the first pair by driving `inv_valid` on the same edge as `req_valid` for a cached page, and expects a walk instead of a hit. It provokes the second by raising `flush_all` together with `walk_done`. In that case the response must still come back, and the next access to that page must walk again, which shows the fill was dropped.

// File: rtl/xc_pkg.sv
package xc_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_PERM = 2'b01,
    CAUSE_WALK = 2'b10
  } cause_e;

  localparam int PERM_W = 4;

  // perm bit 0 readable, 1 writable, 2 executable, 3 user
  function automatic logic perm_ok(input logic [1:0] kind, input logic user,
                                   input logic [PERM_W-1:0] perm);
    logic right;
    case (kind)
      ACC_LOAD:  right = perm[0];
      ACC_STORE: right = perm[1];
      ACC_FETCH: right = perm[2];
      default:   right = 1'b0;
    endcase
    return right && (!user || perm[3]);
  endfunction

endpackage

// File: rtl/xc_entries.sv
module xc_entries #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 36,
  parameter int PPN_W   = 40,
  parameter int PERM_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [PPN_W-1:0]   lk_ppn,
  output logic [PERM_W-1:0]  lk_perm,
  input  logic               inv_en,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic               flush,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic [PERM_W-1:0]  fill_perm,
  output logic [ENTRIES-1:0] valid_vec
);

  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [PPN_W-1:0]  ppn_q  [ENTRIES];
  logic [PERM_W-1:0] perm_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] inv_vec;

  assign valid_vec = valid_q;

  // Payload arrays: written only on fill, no reset, so they map to RAM-style storage.
  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_q[fill_idx]  <= fill_vpn;
      ppn_q[fill_idx]  <= fill_ppn;
      perm_q[fill_idx] <= fill_perm;
    end
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_slot
      assign inv_vec[g] = inv_en && valid_q[g] && (vpn_q[g] == inv_vpn);
      assign hit_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn) && !inv_vec[g];

      always_ff @(posedge clk) begin
        if (rst || flush)
          valid_q[g] <= 1'b0;
        else if (inv_vec[g])
          valid_q[g] <= 1'b0;
        else if (fill_en && fill_idx == IDX_W'(g))
          valid_q[g] <= 1'b1;
      end
    end
  endgenerate

  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        lk_ppn  = lk_ppn | ppn_q[i];
        lk_perm = lk_perm | perm_q[i];
      end
    end
  end
  assign lk_hit = |hit_vec;

  // ---------------- checks ----------------
  logic             inv_q_v;
  logic [VPN_W-1:0] inv_q_vpn;
  logic [ENTRIES-1:0] stale_vec;
  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q_v   <= 1'b0;
      inv_q_vpn <= '0;
    end else begin
      inv_q_v   <= inv_en;
      inv_q_vpn <= inv_vpn;
    end
  end
  always_comb
    for (int i = 0; i < ENTRIES; i++)
      stale_vec[i] = valid_q[i] && (vpn_q[i] == inv_q_vpn);

  assert_one_match_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));
  assert_inval_removes_R7: assert property (@(posedge clk) disable iff (rst)
    inv_q_v |-> (stale_vec == '0));

endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               taken,
  output logic [IDX_W-1:0]   victim
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             all_full;

  assign all_full = &valid_vec;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_vec[i]) free_idx = IDX_W'(i);
  end

  assign victim = all_full ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (rst)
      rr_q <= '0;
    else if (taken && all_full)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  assert_prefer_free_R9: assert property (@(posedge clk) disable iff (rst)
    !all_full |-> !valid_vec[victim]);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 36,
  parameter int PPN_W   = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             walk_done,
  input  logic [PPN_W-1:0] walk_ppn,
  input  logic [3:0]       walk_perm,
  input  logic             walk_fault,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             flush_all
);
  import xc_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);

  typedef enum logic {ST_IDLE, ST_WALK} state_e;

  state_e             state_q;
  logic [1:0]         kind_q;
  logic               user_q;
  logic               lk_hit;
  logic [PPN_W-1:0]   lk_ppn;
  logic [PERM_W-1:0]  lk_perm;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   victim;
  logic               fill_en;
  logic               hit_ok;
  logic               walk_ok;

  assign req_ready = (state_q == ST_IDLE);
  assign hit_ok    = perm_ok(req_kind, req_user, lk_perm);
  assign walk_ok   = perm_ok(kind_q, user_q, walk_perm);
  assign fill_en   = (state_q == ST_WALK) && walk_done && !walk_fault && !flush_all
                     && !(inv_valid && inv_vpn == walk_vpn);

  xc_entries #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
  ) u_entries (
    .clk(clk), .rst(rst),
    .lk_vpn(req_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .inv_en(inv_valid), .inv_vpn(inv_vpn), .flush(flush_all),
    .fill_en(fill_en), .fill_idx(victim), .fill_vpn(walk_vpn),
    .fill_ppn(walk_ppn), .fill_perm(walk_perm),
    .valid_vec(valid_vec)
  );

  xc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .valid_vec(valid_vec), .taken(fill_en), .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      walk_req  <= 1'b0;
      walk_vpn  <= '0;
      kind_q    <= '0;
      user_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_ppn   <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_NONE;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          if (lk_hit) begin
            rsp_valid <= 1'b1;
            rsp_fault <= !hit_ok;
            rsp_cause <= hit_ok ? CAUSE_NONE : CAUSE_PERM;
            rsp_ppn   <= hit_ok ? lk_ppn : '0;
          end else begin
            state_q  <= ST_WALK;
            walk_req <= 1'b1;
            walk_vpn <= req_vpn;
            kind_q   <= req_kind;
            user_q   <= req_user;
          end
        end
        ST_WALK: if (walk_done) begin
          state_q   <= ST_IDLE;
          walk_req  <= 1'b0;
          rsp_valid <= 1'b1;
          if (walk_fault) begin
            rsp_fault <= 1'b1;
            rsp_cause <= CAUSE_WALK;
            rsp_ppn   <= '0;
          end else begin
            rsp_fault <= !walk_ok;
            rsp_cause <= walk_ok ? CAUSE_NONE : CAUSE_PERM;
            rsp_ppn   <= walk_ok ? walk_ppn : '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- checks ----------------
  assert_hit_answers_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && lk_hit) |=> (rsp_valid && !walk_req));
  assert_miss_walks_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !lk_hit) |=> (walk_req && walk_vpn == $past(req_vpn)));
  assert_fault_codes_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault == (rsp_cause != 2'b00)) && (!rsp_fault || rsp_ppn == '0));
  assert_walk_fault_no_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (walk_req && walk_done && walk_fault) |=>
      ($countones(valid_vec) <= $past($countones(valid_vec))));
  assert_busy_no_reply_R11: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !walk_done) |=> !rsp_valid);

endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid = 1'b0;
  logic [35:0] req_vpn = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic        req_ready;
  logic        rsp_valid;
  logic [39:0] rsp_ppn;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic        walk_req;
  logic [35:0] walk_vpn;
  logic        walk_done = 1'b0;
  logic [39:0] walk_ppn = '0;
  logic [3:0]  walk_perm = '0;
  logic        walk_fault = 1'b0;
  logic        inv_valid = 1'b0;
  logic [35:0] inv_vpn = '0;
  logic        flush_all = 1'b0;

  int checks = 0;
  int fails  = 0;

  // walker model settings and per-access options
  logic [39:0] w_ppn;
  logic [3:0]  w_perm;
  logic        w_fault;
  bit opt_stray = 0, opt_inv = 0, opt_flush = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_kind(req_kind), .req_user(req_user),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_done(walk_done),
    .walk_ppn(walk_ppn), .walk_perm(walk_perm), .walk_fault(walk_fault),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush_all(flush_all)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_walk(input logic [39:0] p, input logic [3:0] pm, input logic f);
    w_ppn = p; w_perm = pm; w_fault = f;
  endtask

  // One access; the walker model answers if a walk is requested.
  task automatic access(input logic [35:0] vpn, input logic [1:0] kind, input bit user,
                        input bit exp_walk, input bit exp_fault, input logic [1:0] exp_cause,
                        input logic [39:0] exp_ppn, input string req);
    bit walked = 0;
    @(negedge clk);
    req_valid = 1; req_vpn = vpn; req_kind = kind; req_user = user;
    if (opt_inv) begin inv_valid = 1; inv_vpn = vpn; end
    @(negedge clk);
    req_valid = 0; inv_valid = 0;
    if (walk_req) begin
      walked = 1;
      check(walk_vpn == vpn, req, "walk_vpn", walk_vpn, vpn);
      check(req_ready == 1'b0, "R11", "req_ready during walk", req_ready, 0);
      if (opt_stray) begin
        req_valid = 1; req_vpn = vpn + 36'h77;
        @(negedge clk);
        req_valid = 0;
        check(rsp_valid == 1'b0, "R11", "reply to ignored request", rsp_valid, 0);
        check(walk_vpn == vpn, "R11", "walk_vpn kept", walk_vpn, vpn);
      end
      walk_done = 1; walk_ppn = w_ppn; walk_perm = w_perm; walk_fault = w_fault;
      if (opt_flush) flush_all = 1;
      @(negedge clk);
      walk_done = 0; flush_all = 0;
    end
    check(walked == exp_walk, req, "walk taken", walked, exp_walk);
    check(rsp_valid == 1'b1, req, "rsp_valid", rsp_valid, 1);
    check(rsp_fault == exp_fault, req, "rsp_fault", rsp_fault, exp_fault);
    check(rsp_cause == exp_cause, req, "rsp_cause", rsp_cause, exp_cause);
    check(rsp_ppn == exp_ppn, req, "rsp_ppn", rsp_ppn, exp_ppn);
  endtask

  task automatic inval(input logic [35:0] vpn);
    @(negedge clk); inv_valid = 1; inv_vpn = vpn;
    @(negedge clk); inv_valid = 0;
  endtask

  task automatic flush();
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
  endtask

  task automatic t_reset();  // R12
    @(negedge clk);
    check(req_ready == 1'b1, "R12", "req_ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R12", "rsp_valid", rsp_valid, 0);
    check(walk_req == 1'b0, "R12", "walk_req", walk_req, 0);
    set_walk(40'h5005, 4'b0001, 0);
    access(36'h5, 2'b00, 0, 1, 0, 2'b00, 40'h5005, "R12");
  endtask

  task automatic t_miss_then_hit();  // R1 R2
    set_walk(40'hABC, 4'b0011, 0);
    access(36'h100, 2'b00, 0, 1, 0, 2'b00, 40'hABC, "R2");
    set_walk(40'hDEAD, 4'b0011, 0);
    access(36'h100, 2'b01, 0, 0, 0, 2'b00, 40'hABC, "R1");
  endtask

  task automatic t_perms();  // R3 R4 R5
    set_walk(40'h200, 4'b0001, 0);
    access(36'h200, 2'b00, 0, 1, 0, 2'b00, 40'h200, "R3");
    access(36'h200, 2'b01, 0, 0, 1, 2'b01, 40'h0, "R3");
    access(36'h200, 2'b10, 0, 0, 1, 2'b01, 40'h0, "R3");
    access(36'h200, 2'b11, 0, 0, 1, 2'b01, 40'h0, "R3");
    access(36'h200, 2'b00, 1, 0, 1, 2'b01, 40'h0, "R4");
    set_walk(40'h201, 4'b1101, 0);
    access(36'h201, 2'b10, 1, 1, 0, 2'b00, 40'h201, "R4");
    access(36'h201, 2'b01, 1, 0, 1, 2'b01, 40'h0, "R4");
    set_walk(40'h202, 4'b0001, 0);
    access(36'h202, 2'b01, 0, 1, 1, 2'b01, 40'h0, "R5");
    access(36'h202, 2'b00, 0, 0, 0, 2'b00, 40'h202, "R5");
  endtask

  task automatic t_walk_fault();  // R6
    set_walk(40'h300, 4'b1111, 1);
    access(36'h300, 2'b00, 0, 1, 1, 2'b10, 40'h0, "R6");
    set_walk(40'h301, 4'b1111, 0);
    access(36'h300, 2'b00, 0, 1, 0, 2'b00, 40'h301, "R6");
  endtask

  task automatic t_shared_write();  // R3 R7
    set_walk(40'h400, 4'b1001, 0);
    access(36'h400, 2'b00, 1, 1, 0, 2'b00, 40'h400, "R3");
    access(36'h400, 2'b01, 1, 0, 1, 2'b01, 40'h0, "R3");
    inval(36'h400);
    set_walk(40'h4444, 4'b1011, 0);
    access(36'h400, 2'b01, 1, 1, 0, 2'b00, 40'h4444, "R7");
    access(36'h400, 2'b01, 1, 0, 0, 2'b00, 40'h4444, "R7");
    access(36'h100, 2'b00, 0, 0, 0, 2'b00, 40'hABC, "R7");
  endtask

  task automatic t_flush();  // R8
    flush();
    set_walk(40'hF100, 4'b0011, 0);
    access(36'h100, 2'b00, 0, 1, 0, 2'b00, 40'hF100, "R8");
    set_walk(40'hF400, 4'b1011, 0);
    access(36'h400, 2'b00, 1, 1, 0, 2'b00, 40'hF400, "R8");
  endtask

  task automatic t_replace();  // R9
    flush();
    for (int i = 0; i < 8; i++) begin
      set_walk(40'h1500 + 40'(i), 4'b0001, 0);
      access(36'h500 + 36'(i), 2'b00, 0, 1, 0, 2'b00, 40'h1500 + 40'(i), "R9");
    end
    inval(36'h503);
    set_walk(40'h1508, 4'b0001, 0);
    access(36'h508, 2'b00, 0, 1, 0, 2'b00, 40'h1508, "R9");
    access(36'h507, 2'b00, 0, 0, 0, 2'b00, 40'h1507, "R9");
    access(36'h500, 2'b00, 0, 0, 0, 2'b00, 40'h1500, "R9");
    set_walk(40'h1509, 4'b0001, 0);
    access(36'h509, 2'b00, 0, 1, 0, 2'b00, 40'h1509, "R9");
    for (int i = 1; i < 10; i++) begin
      if (i != 3)
        access(36'h500 + 36'(i), 2'b00, 0, 0, 0, 2'b00, 40'h1500 + 40'(i), "R9");
    end
    set_walk(40'h2500, 4'b0001, 0);
    access(36'h500, 2'b00, 0, 1, 0, 2'b00, 40'h2500, "R9");
    set_walk(40'h2501, 4'b0001, 0);
    access(36'h501, 2'b00, 0, 1, 0, 2'b00, 40'h2501, "R9");
  endtask

  task automatic t_same_cycle();  // R10
    set_walk(40'h600, 4'b0001, 0);
    access(36'h600, 2'b00, 0, 1, 0, 2'b00, 40'h600, "R10");
    opt_inv = 1;
    set_walk(40'h6600, 4'b0001, 0);
    access(36'h600, 2'b00, 0, 1, 0, 2'b00, 40'h6600, "R10");
    opt_inv = 0;
    opt_flush = 1;
    set_walk(40'h700, 4'b0001, 0);
    access(36'h700, 2'b00, 0, 1, 0, 2'b00, 40'h700, "R10");
    opt_flush = 0;
    set_walk(40'h7700, 4'b0001, 0);
    access(36'h700, 2'b00, 0, 1, 0, 2'b00, 40'h7700, "R10");
  endtask

  task automatic t_busy();  // R11
    opt_stray = 1;
    set_walk(40'h800, 4'b0001, 0);
    access(36'h800, 2'b00, 0, 1, 0, 2'b00, 40'h800, "R11");
    opt_stray = 0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11", "single response", rsp_valid, 0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_miss_then_hit();
    t_perms();
    t_walk_fault();
    t_shared_write();
    t_flush();
    t_replace();
    t_same_cycle();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule